// File: doc/BRIEF.md
# SDRAM Refresh and Command Requester

This block works beside an SDRAM command sequencer in the memory clock domain. It decides *when* an auto-refresh or a precharge-all has to be issued. It leaves *how* those commands are timed on the memory pins to the sequencer. Requests come from two sources:

- a programmable periodic refresh timer, whose period is set in units of 64 clocks;
- two software trigger bits in a control word, which ask for one extra refresh or one precharge-all.

Each command type has its own request/acknowledge pair toward the sequencer. Only one request is presented at a time.

The same control word holds the static settings the sequencer and the pad logic need: one output-enable qualifier for each data strobe, and a flag that selects a 16-bit data port on the upper byte lanes instead of a 32-bit one.

The control word is written and read through a simple register port. A write takes effect at the clock edge on which it is presented.

Periodic refreshes the sequencer cannot take in time are not lost. They build up in a saturating backlog count, and the periodic request stays raised until that backlog has been drained.

Top module: `sdram_ref_requester`

## Requirements
- R1: After reset the control word reads back with the interval field equal to the parameter `RST_INTERVAL` (default 3) and all other bits 0. No request is raised, the backlog count is 0, the strobe enables are 0 and the port-size flag is 0.
- R2: The periodic timer expires every (interval+1)×64 clocks. The first expiry is at the 64×(`RST_INTERVAL`+1)-th rising edge after reset is released, and from that edge the periodic refresh request is raised. A new interval value is loaded only at the next expiry, so the period already running is finished with the old value.
- R3: The control word layout is:
  - bits 5:0: refresh interval;
  - bits 11:8: strobe enables;
  - bit 12: port size (1 = 16-bit);
  - bit 13: mode enable;
  - bit 14: software-refresh trigger;
  - bit 15: software-precharge trigger.

  Bits 7:6, 14 and 15 always read back as 0.
- R4: A write with bits 13 and 14 both set leaves one software refresh pending from the next cycle on. It stays pending until it is acknowledged. It does not change the phase or the period of the periodic timer.
- R5: A write with bits 13 and 15 both set leaves one precharge-all pending from the next cycle on. Its request stays high until it is acknowledged.
- R6: When bit 13 of the written word is 0, bits 14 and 15 of that word are ignored and no request results from them.
- R7: While a precharge-all is pending, neither refresh request is raised.
- R8: At most one request is high in any cycle. A pending periodic refresh is presented before a pending software refresh, and both are issued as separate commands. An acknowledge counts only in a cycle in which its own request is high.
- R9: An expiry that occurs while a periodic refresh is already pending raises the backlog count by one, up to a ceiling of 8. Each acknowledged periodic refresh first takes one from the backlog and keeps the request raised. The request drops only when the backlog is 0.
- R10: The strobe-enable output equals bits 11:8 of the control word, and the port-size output equals bit 12. When the parameter `DDR_STROBES` is 0, the strobe enables are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback |
| prd_ref_req | output | 1 | Periodic auto-refresh request |
| prd_ref_ack | input | 1 | Sequencer accepts the periodic refresh |
| sw_ref_req | output | 1 | Software auto-refresh request |
| sw_ref_ack | input | 1 | Sequencer accepts the software refresh |
| pall_req | output | 1 | Precharge-all request |
| pall_ack | input | 1 | Sequencer accepts the precharge-all |
| strobe_oe | output | 4 | Per-strobe output-enable qualifiers |
| port_is_16 | output | 1 | 1 = 16-bit data port on the upper lanes |
| ref_backlog | output | 4 | Postponed periodic refresh count, 0..8 |

## Verification
The embedded properties watch the following on every cycle:

- at most one request is high;
- precharge-all has precedence over both refreshes;
- an unacknowledged request stays up;
- the backlog never passes its ceiling;
- the write-only bits read as zero;
- two timer expiries are never adjacent.

Only the bench's scenarios can show the things that need a count of cycles or a history of writes:

- the exact expiry edge for a given interval;
- that a changed interval waits for the next expiry;
- that a software refresh leaves the timer phase alone;
- that triggers written with mode enable clear vanish;
- that the backlog drains one acknowledge at a time.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
   // control word geometry
   localparam int CTRL_W     = 16;
   localparam int IVL_W      = 6;
   localparam int IVL_LSB    = 0;
   localparam int OE_W       = 4;
   localparam int OE_LSB     = 8;
   localparam int P16_BIT    = 12;
   localparam int MODE_BIT   = 13;
   localparam int SWREF_BIT  = 14;
   localparam int SWPALL_BIT = 15;

   typedef enum logic [1:0] {
      GNT_NONE = 2'd0,
      GNT_PALL = 2'd1,
      GNT_PRD  = 2'd2,
      GNT_SW   = 2'd3
   } gnt_e;
endpackage

// File: rtl/sdram_ref_regs.sv
module sdram_ref_regs
   import sdram_ref_pkg::*;
#(
   parameter int RST_INTERVAL = 3,
   parameter bit DDR_STROBES  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] rdata,
   output logic [IVL_W-1:0]  ivl,
   output logic [OE_W-1:0]   strobe_oe,
   output logic              port16,
   output logic              sw_ref_set,
   output logic              pall_set
);
   initial begin
      assert (RST_INTERVAL >= 0 && RST_INTERVAL < (1 << IVL_W))
         else $error("RST_INTERVAL does not fit the interval field");
   end

   logic [IVL_W-1:0] ivl_q;
   logic             p16_q;
   logic             mode_q;
   logic [1:0]       unused_rsv;

   assign unused_rsv = wdata[7:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl_q  <= IVL_W'(RST_INTERVAL);
         p16_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (wr) begin
         ivl_q  <= wdata[IVL_LSB +: IVL_W];
         p16_q  <= wdata[P16_BIT];
         mode_q <= wdata[MODE_BIT];
      end
   end

   generate
      if (DDR_STROBES) begin : g_ddr_oe
         logic [OE_W-1:0] oe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  oe_q <= '0;
            else if (wr) oe_q <= wdata[OE_LSB +: OE_W];
         end
         assign strobe_oe = oe_q;
      end else begin : g_sdr_oe
         logic [OE_W-1:0] unused_oe;
         assign unused_oe = wdata[OE_LSB +: OE_W];
         assign strobe_oe = '0;
      end
   endgenerate

   // triggers only count when the same word carries mode enable
   assign sw_ref_set = wr & wdata[MODE_BIT] & wdata[SWREF_BIT];
   assign pall_set   = wr & wdata[MODE_BIT] & wdata[SWPALL_BIT];

   assign ivl    = ivl_q;
   assign port16 = p16_q;

   always_comb begin
      rdata                       = '0;
      rdata[IVL_LSB +: IVL_W]     = ivl_q;
      rdata[OE_LSB +: OE_W]       = strobe_oe;
      rdata[P16_BIT]              = p16_q;
      rdata[MODE_BIT]             = mode_q;
   end

   AST_WO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[SWREF_BIT] == 1'b0) && (rdata[SWPALL_BIT] == 1'b0)); // R3
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer
   import sdram_ref_pkg::*;
#(
   parameter int RST_INTERVAL  = 3,
   parameter int PRESCALE_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] ivl,
   output logic             expire
);
   initial begin
      assert (PRESCALE_LOG2 >= 1 && PRESCALE_LOG2 <= 16)
         else $error("PRESCALE_LOG2 out of range");
   end

   logic [PRESCALE_LOG2-1:0] pre_q;
   logic [IVL_W-1:0]         unit_q;
   logic                     tick;

   assign tick   = &pre_q;
   assign expire = tick && (unit_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         unit_q <= IVL_W'(RST_INTERVAL);
      end else begin
         pre_q <= pre_q + 1'b1;
         if (tick) begin
            // interval register is sampled only at reload
            if (unit_q == '0) unit_q <= ivl;
            else              unit_q <= unit_q - 1'b1;
         end
      end
   end

   AST_EXPIRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire); // R2
endmodule

// File: rtl/sdram_ref_arb.sv
module sdram_ref_arb
   import sdram_ref_pkg::*;
#(
   parameter int BACKLOG_MAX = 8,
   localparam int OWED_MAX   = BACKLOG_MAX + 1,
   localparam int OWED_W     = $clog2(OWED_MAX + 1),
   localparam int BL_W       = $clog2(BACKLOG_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            expire,
   input  logic            sw_ref_set,
   input  logic            pall_set,
   input  logic            prd_ack,
   input  logic            sw_ack,
   input  logic            pall_ack,
   output logic            prd_req,
   output logic            sw_req,
   output logic            pall_req,
   output logic [BL_W-1:0] backlog
);
   initial begin
      assert (BACKLOG_MAX >= 1) else $error("BACKLOG_MAX must be at least 1");
   end

   logic [OWED_W-1:0] owed_q;   // periodic refreshes owed, incl. the one presented
   logic              sw_q;
   logic              pall_q;
   gnt_e              gnt;
   logic              prd_taken, sw_taken, pall_taken;

   always_comb begin
      if (pall_q)               gnt = GNT_PALL;
      else if (owed_q != '0)    gnt = GNT_PRD;
      else if (sw_q)            gnt = GNT_SW;
      else                      gnt = GNT_NONE;
   end

   assign prd_taken  = (gnt == GNT_PRD)  && prd_ack;
   assign sw_taken   = (gnt == GNT_SW)   && sw_ack;
   assign pall_taken = (gnt == GNT_PALL) && pall_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
         sw_q   <= 1'b0;
         pall_q <= 1'b0;
      end else begin
         case ({expire, prd_taken})
            2'b10:   if (owed_q != OWED_W'(OWED_MAX)) owed_q <= owed_q + 1'b1;
            2'b01:   owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
         sw_q   <= (sw_q   & ~sw_taken)   | sw_ref_set;
         pall_q <= (pall_q & ~pall_taken) | pall_set;
      end
   end

   assign pall_req = (gnt == GNT_PALL);
   assign prd_req  = (gnt == GNT_PRD);
   assign sw_req   = (gnt == GNT_SW);
   assign backlog  = (owed_q == '0) ? '0 : BL_W'(owed_q - 1'b1);

   AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pall_req, prd_req, sw_req})); // R8
   AST_PALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      pall_req |-> (!prd_req && !sw_req)); // R7
   AST_PALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pall_req && !pall_ack) |=> pall_req); // R5
   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !sw_ack) |=> (sw_req || pall_req || prd_req)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      backlog <= BL_W'(BACKLOG_MAX)); // R9
   AST_BACKLOG_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (backlog != '0) |-> (prd_req || pall_req)); // R9
endmodule

// File: rtl/sdram_ref_requester.sv
module sdram_ref_requester
   import sdram_ref_pkg::*;
#(
   parameter int RST_INTERVAL  = 3,
   parameter int PRESCALE_LOG2 = 6,
   parameter int BACKLOG_MAX   = 8,
   parameter bit DDR_STROBES   = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 reg_wr,
   input  logic [CTRL_W-1:0]                    reg_wdata,
   output logic [CTRL_W-1:0]                    reg_rdata,
   output logic                                 prd_ref_req,
   input  logic                                 prd_ref_ack,
   output logic                                 sw_ref_req,
   input  logic                                 sw_ref_ack,
   output logic                                 pall_req,
   input  logic                                 pall_ack,
   output logic [OE_W-1:0]                      strobe_oe,
   output logic                                 port_is_16,
   output logic [$clog2(BACKLOG_MAX+1)-1:0]     ref_backlog
);
   logic [IVL_W-1:0] ivl;
   logic             sw_ref_set, pall_set, expire;

   sdram_ref_regs #(
      .RST_INTERVAL (RST_INTERVAL),
      .DDR_STROBES  (DDR_STROBES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .ivl        (ivl),
      .strobe_oe  (strobe_oe),
      .port16     (port_is_16),
      .sw_ref_set (sw_ref_set),
      .pall_set   (pall_set)
   );

   sdram_ref_timer #(
      .RST_INTERVAL  (RST_INTERVAL),
      .PRESCALE_LOG2 (PRESCALE_LOG2)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .ivl    (ivl),
      .expire (expire)
   );

   sdram_ref_arb #(
      .BACKLOG_MAX (BACKLOG_MAX)
   ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .sw_ref_set (sw_ref_set),
      .pall_set   (pall_set),
      .prd_ack    (prd_ref_ack),
      .sw_ack     (sw_ref_ack),
      .pall_ack   (pall_ack),
      .prd_req    (prd_ref_req),
      .sw_req     (sw_ref_req),
      .pall_req   (pall_req),
      .backlog    (ref_backlog)
   );
endmodule

// File: tb/sdram_ref_requester_tb.sv
module sdram_ref_requester_tb;
   localparam int RST_IVL = 3;
   localparam int PRE     = 64;
   localparam int BL_MAX  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        prd_ref_req, sw_ref_req, pall_req;
   logic        prd_ref_ack = 1'b0, sw_ref_ack = 1'b0, pall_ack = 1'b0;
   logic [3:0]  strobe_oe;
   logic        port_is_16;
   logic [3:0]  ref_backlog;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdram_ref_requester #(
      .RST_INTERVAL (RST_IVL),
      .PRESCALE_LOG2(6),
      .BACKLOG_MAX  (BL_MAX),
      .DDR_STROBES  (1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .prd_ref_req(prd_ref_req), .prd_ref_ack(prd_ref_ack),
      .sw_ref_req(sw_ref_req), .sw_ref_ack(sw_ref_ack), .pall_req(pall_req),
      .pall_ack(pall_ack), .strobe_oe(strobe_oe), .port_is_16(port_is_16),
      .ref_backlog(ref_backlog)
   );

   // ---------------- behavioural reference model ----------------
   int m_ivl, m_oe, m_p16, m_mode, m_rem, m_owed, m_sw, m_pall;

   function automatic bit mq_pall(); return m_pall != 0; endfunction
   function automatic bit mq_prd();  return (m_owed > 0) && (m_pall == 0); endfunction
   function automatic bit mq_sw();   return (m_sw != 0) && (m_pall == 0) && (m_owed == 0); endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ivl = RST_IVL; m_oe = 0; m_p16 = 0; m_mode = 0;
         m_rem = (RST_IVL + 1) * PRE; m_owed = 0; m_sw = 0; m_pall = 0;
      end else begin
         bit qp, qr, qs, exp_now, took;
         qp = mq_pall(); qr = mq_prd(); qs = mq_sw();
         exp_now = (m_rem == 1);
         if (exp_now) m_rem = (m_ivl + 1) * PRE;
         else         m_rem = m_rem - 1;
         took = qr && prd_ref_ack;
         if (exp_now && !took)      m_owed = (m_owed < BL_MAX + 1) ? m_owed + 1 : m_owed;
         else if (!exp_now && took) m_owed = m_owed - 1;
         if (qp && pall_ack)   m_pall = 0;
         if (qs && sw_ref_ack) m_sw = 0;
         if (reg_wr) begin
            if (reg_wdata[13] && reg_wdata[14]) m_sw = 1;
            if (reg_wdata[13] && reg_wdata[15]) m_pall = 1;
            m_ivl  = int'(reg_wdata[5:0]);
            m_oe   = int'(reg_wdata[11:8]);
            m_p16  = int'(reg_wdata[12]);
            m_mode = int'(reg_wdata[13]);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every falling edge once out of reset
   always @(negedge clk) begin
      if (rst_n) begin
         int exp_rd;
         exp_rd = (m_mode << 13) | (m_p16 << 12) | (m_oe << 8) | m_ivl;
         chk("R2,R4,R5,R7,R8", "prd_ref_req", int'(prd_ref_req), int'(mq_prd()));
         chk("R4,R8",          "sw_ref_req",  int'(sw_ref_req),  int'(mq_sw()));
         chk("R5,R7",          "pall_req",    int'(pall_req),    int'(mq_pall()));
         chk("R9", "ref_backlog", int'(ref_backlog), (m_owed > 0) ? m_owed - 1 : 0);
         chk("R3", "reg_rdata",   int'(reg_rdata),   exp_rd);
         chk("R10", "strobe_oe",  int'(strobe_oe),   m_oe);
         chk("R10", "port_is_16", int'(port_is_16),  m_p16);
      end
   end

   // ---------------- stimulus ----------------
   bit          a_prd = 0, a_sw = 0, a_pall = 0, a_rand = 0, w_rand = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (a_rand) begin
            prd_ref_ack = lfsr[0]; sw_ref_ack = lfsr[2]; pall_ack = lfsr[5];
         end else begin
            prd_ref_ack = a_prd; sw_ref_ack = a_sw; pall_ack = a_pall;
         end
         if (w_rand && lfsr[14:12] == 3'b000) begin
            reg_wr = 1'b1;
            reg_wdata = {lfsr[11], lfsr[10], lfsr[9], lfsr[8], lfsr[7:4],
                         lfsr[13:12], 4'b0000, lfsr[1:0]};
         end else begin
            reg_wr = 1'b0;
         end
         @(negedge clk);
      end
      reg_wr = 1'b0;
   endtask

   task automatic wr_word(input logic [15:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset rdata",   int'(reg_rdata),   RST_IVL);
      chk("R1", "reset reqs",    int'({prd_ref_req, sw_ref_req, pall_req}), 0);
      chk("R1", "reset backlog", int'(ref_backlog), 0);
      chk("R1", "reset oe/p16",  int'({strobe_oe, port_is_16}), 0);
      rst_n = 1'b1;

      // R2 first expiry at edge 64*(RST_IVL+1)
      run((RST_IVL + 1) * PRE - 1);
      chk("R2", "no req before expiry", int'(prd_ref_req), 0);
      run(1);
      chk("R2", "req at expiry", int'(prd_ref_req), 1);

      // R3 R10 configuration, interval 0, mode on
      wr_word(16'h3A00);
      chk("R3",  "rdata after cfg", int'(reg_rdata), 16'h3A00);
      chk("R10", "strobe_oe",       int'(strobe_oe), 4'hA);
      chk("R10", "port_is_16",      int'(port_is_16), 1);

      // R9 backlog saturates with no acks
      run(PRE * 14);
      chk("R9", "backlog saturated", int'(ref_backlog), BL_MAX);

      // R8 software refresh waits behind periodic
      wr_word(16'h7A00);
      chk("R8", "sw masked by prd", int'(sw_ref_req), 0);
      chk("R3", "trigger reads 0",  int'(reg_rdata), 16'h3A00);
      // R7 precharge-all preempts
      wr_word(16'hBA00);
      chk("R7", "pall first", int'({pall_req, prd_ref_req, sw_ref_req}), 3'b100);
      run(5);
      chk("R5", "pall held", int'(pall_req), 1);

      // drain everything
      a_prd = 1; a_sw = 1; a_pall = 1;
      run(30);
      chk("R9", "backlog drained", int'(ref_backlog), 0);

      // R6 triggers ignored with mode clear
      a_sw = 0; a_pall = 0;
      wr_word(16'hDA00);
      run(3);
      chk("R6", "sw ignored",   int'(sw_ref_req), 0);
      chk("R6", "pall ignored", int'(pall_req), 0);

      // R4 software refresh raised with mode set, held until ack
      wr_word(16'h7A00);
      run(3);
      chk("R4", "sw pending", int'(sw_ref_req), 1);
      a_sw = 1;
      run(2);
      chk("R4", "sw cleared", int'(sw_ref_req), 0);

      // R2 interval change waits for next expiry (model tracks phase)
      a_prd = 0;
      wr_word(16'h0002);
      run(PRE * 8);

      // mixed random traffic
      a_rand = 1; w_rand = 1;
      run(4000);
      a_rand = 0; w_rand = 0; a_prd = 1; a_sw = 1; a_pall = 1;
      run(40);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule